// File: doc/BRIEF.md
# Real-Time Clock Event Flags and Interrupt Summary

This block holds the event status of a real-time clock. It watches a timekeeper's update window, compares the time that results against a programmed alarm, and divides a base tick into a periodic event at a rate that software selects. Each of the three events latches a sticky flag. The flags appear in an 8-bit status word. A single read strobe on that word clears every flag.

Each event has an enable bit. An enable does not decide whether its flag latches. It only decides whether a latched flag counts toward the summary bit and the interrupt line. The block also copies the timekeeper's busy level to an update-in-progress output, so that software can avoid reading the time while the time is changing.

Top module: `rtc_event_flags`

## Requirements
- R1: While `rst_n` is low, and after reset until the first event, `stat_c` reads 0x00 and `irq` and `uip` read 0. This holds even when `upd_busy` is high during reset.
- R2: Status word layout: bit 7 is the summary, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bits 3:0 always read 0.
- R3: A flag sets on its event whether or not its bit in `ev_en` is set.
- R4: `ev_en` bit 2 enables the periodic source, bit 1 the alarm source and bit 0 the update-ended source. `stat_c[7]` is the OR of each flag ANDed with its enable, and `irq` always equals `stat_c[7]`.
- R5: A cycle with `stat_rd` high clears all three flags at the next clock edge.
- R6: If an event and `stat_rd` fall in the same cycle, that event's flag is set after the edge.
- R7: With `rate_sel` = 0, base ticks never set the periodic flag.
- R8: With `rate_sel` = N (1 to 15), a base tick raises the periodic event when the count of ticks seen since reset, taken before that tick, has its low N-1 bits all ones. The event therefore comes every 2^(N-1) ticks, and the flag shows it one cycle later.
- R9: `uip` equals `upd_busy` delayed by one cycle. The update-ended event fires in the first cycle where `upd_busy` is low after `uip` was high, and the flag shows it one cycle later.
- R10: When an update ends, the alarm event fires if seconds, minutes and hour equal their alarm values and either `alm_date` is 0 (date ignored) or the date equals `alm_date`.
- R11: An update that ends with any compared field unequal leaves the alarm flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse of the base periodic rate |
| upd_busy | input | 1 | Timekeeper is updating the time registers |
| rate_sel | input | 4 | Periodic rate select, 0 = off |
| ev_en | input | 3 | Interrupt enables {periodic, alarm, update-ended} |
| stat_rd | input | 1 | Read strobe of the status word, clears the flags |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hour | input | 8 | Current hour |
| now_date | input | 8 | Current day of month |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hour |
| alm_date | input | 8 | Alarm day of month, 0 = not compared |
| stat_c | output | 8 | Status word |
| irq | output | 1 | Interrupt request, active high |
| uip | output | 1 | Update in progress |

## Verification
The bench tests an event that coincides with a read. A design in which the clear wins would drop that event without any trace.

It holds the read strobe high while the divider runs at several rates. Any off-by-one error in the tick mask then shows up as a periodic flag in the wrong cycle.

It ends updates against an alarm that differs only in the date, and against an alarm whose date is 0. A compare that ignores the date, or one that treats 0 as a real date, would then set the alarm flag or miss it.

It also moves the enables while flags are held. This exposes any design that gates the flags themselves instead of the summary bit.

// File: rtl/rtc_flags_pkg.sv
package rtc_flags_pkg;
   localparam int unsigned SRC_N    = 3;
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned FLAG_LSB = 4;
   typedef enum int unsigned {
      SRC_UPD = 0,
      SRC_ALM = 1,
      SRC_PER = 2
   } src_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int unsigned TW       = 8,
   parameter bit          DATE_CMP = 1'b1
) (
   input  logic [TW-1:0] now_sec,
   input  logic [TW-1:0] now_min,
   input  logic [TW-1:0] now_hour,
   input  logic [TW-1:0] now_date,
   input  logic [TW-1:0] alm_sec,
   input  logic [TW-1:0] alm_min,
   input  logic [TW-1:0] alm_hour,
   input  logic [TW-1:0] alm_date,
   output logic          match
);
   logic tod_eq;
   logic date_ok;

   assign tod_eq = (now_sec == alm_sec) && (now_min == alm_min) && (now_hour == alm_hour);

   generate
      if (DATE_CMP) begin : g_date
         assign date_ok = (alm_date == '0) || (now_date == alm_date);
      end else begin : g_nodate
         logic unused_date;
         assign unused_date = ^{now_date, alm_date};
         assign date_ok = 1'b1;
      end
   endgenerate

   assign match = tod_eq && date_ok;
endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
   parameter int unsigned RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              per_evt
);
   localparam int unsigned CNT_W = (1 << RATE_W) - 2;

   logic [CNT_W-1:0] tick_cnt;
   logic [CNT_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tick_cnt <= '0;
      else if (base_tick) tick_cnt <= tick_cnt + 1'b1;
   end

   always_comb begin
      mask = '0;
      for (int i = 0; i < CNT_W; i++) begin
         mask[i] = (rate_sel != '0) && (i < (int'(rate_sel) - 1));
      end
   end

   assign per_evt = base_tick && (rate_sel != '0) && ((tick_cnt & mask) == mask);

   p_per_needs_tick_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      per_evt |-> base_tick);
endmodule

// File: rtl/rtc_event_flag.sv
module rtc_event_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic rd,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (evt) flag <= 1'b1;
      else if (rd)  flag <= 1'b0;
   end

   p_evt_wins_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);
   p_rd_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !evt) |=> !flag);
   p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!rd && !evt) |=> $stable(flag));
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
   import rtc_flags_pkg::*;
#(
   parameter int unsigned TW       = 8,
   parameter int unsigned RATE_W   = 4,
   parameter bit          DATE_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              upd_busy,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [SRC_N-1:0]  ev_en,
   input  logic              stat_rd,
   input  logic [TW-1:0]     now_sec,
   input  logic [TW-1:0]     now_min,
   input  logic [TW-1:0]     now_hour,
   input  logic [TW-1:0]     now_date,
   input  logic [TW-1:0]     alm_sec,
   input  logic [TW-1:0]     alm_min,
   input  logic [TW-1:0]     alm_hour,
   input  logic [TW-1:0]     alm_date,
   output logic [STAT_W-1:0] stat_c,
   output logic              irq,
   output logic              uip
);
   localparam int unsigned PAD_W = FLAG_LSB;

   generate
      if (TW < 6) begin : g_bad_tw
         $error("rtc_event_flags: TW must hold a value up to 59");
      end
      if (RATE_W < 2 || RATE_W > 5) begin : g_bad_rate
         $error("rtc_event_flags: RATE_W must lie in 2..5");
      end
   endgenerate

   logic             uip_q;
   logic             upd_evt;
   logic             alm_match;
   logic             per_evt;
   logic [SRC_N-1:0] evt;
   logic [SRC_N-1:0] flags;
   logic             irq_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) uip_q <= 1'b0;
      else        uip_q <= upd_busy;
   end

   assign upd_evt = uip_q && !upd_busy;

   rtc_alarm_cmp #(.TW(TW), .DATE_CMP(DATE_CMP)) alarm_i (
      .now_sec (now_sec),  .now_min (now_min),
      .now_hour(now_hour), .now_date(now_date),
      .alm_sec (alm_sec),  .alm_min (alm_min),
      .alm_hour(alm_hour), .alm_date(alm_date),
      .match   (alm_match)
   );

   rtc_periodic_div #(.RATE_W(RATE_W)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_tick(base_tick),
      .rate_sel (rate_sel),
      .per_evt  (per_evt)
   );

   assign evt[SRC_UPD] = upd_evt;
   assign evt[SRC_ALM] = upd_evt && alm_match;
   assign evt[SRC_PER] = per_evt;

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
         rtc_event_flag flag_i (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt[s]),
            .rd   (stat_rd),
            .flag (flags[s])
         );
      end
   endgenerate

   assign irq_sum = |(flags & ev_en);
   assign stat_c  = {irq_sum, flags, {PAD_W{1'b0}}};
   assign irq     = irq_sum;
   assign uip     = uip_q;

   p_uip_follow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      upd_busy |=> uip);
   p_irq_has_src_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((stat_c[FLAG_LSB +: SRC_N] & ev_en) != '0));
   p_alarm_at_update_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      evt[SRC_ALM] |-> upd_evt);
   p_rate0_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |-> !per_evt);
endmodule

// File: tb/rtc_event_flags_tb.sv
module rtc_event_flags_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       upd_busy = 1'b0;
   logic [3:0] rate_sel = '0;
   logic [2:0] ev_en = '0;
   logic       stat_rd = 1'b0;
   logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
   logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0, alm_date = '0;
   logic [7:0] stat_c;
   logic       irq;
   logic       uip;

   int checks = 0;
   int fails  = 0;

   typedef struct packed {
      logic [2:0] f;
      logic       u;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];

   logic [2:0] m_f = '0;
   logic       m_uip = 1'b0;
   int         m_ticks = 0;

   always #(CLK_P/2) clk = ~clk;

   rtc_event_flags dut_i (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .upd_busy(upd_busy),
      .rate_sel(rate_sel), .ev_en(ev_en), .stat_rd(stat_rd),
      .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
      .stat_c(stat_c), .irq(irq), .uip(uip)
   );

   task automatic step(input string tag);
      logic [2:0] e;
      int mask;
      exp_t it;
      @(posedge clk);
      e = '0;
      if (base_tick) begin
         mask = (rate_sel == 0) ? 0 : ((1 << (int'(rate_sel) - 1)) - 1);
         e[2] = (rate_sel != 0) && ((m_ticks & mask) == mask);
         m_ticks++;
      end
      e[0] = m_uip && !upd_busy;
      e[1] = e[0] && now_sec == alm_sec && now_min == alm_min && now_hour == alm_hour
             && (alm_date == 0 || now_date == alm_date);
      for (int i = 0; i < 3; i++) begin
         if (e[i]) m_f[i] = 1'b1;
         else if (stat_rd) m_f[i] = 1'b0;
      end
      m_uip = upd_busy;
      it.f = m_f;
      it.u = m_uip;
      expq.push_back(it);
      tagq.push_back(tag);
      #1;
   endtask

   always @(negedge clk) begin
      if (expq.size() > 0) begin
         exp_t it;
         string t;
         logic b7;
         logic [7:0] es;
         it = expq.pop_front();
         t  = tagq.pop_front();
         b7 = |(it.f & ev_en);
         es = {b7, it.f, 4'b0000};
         checks++;
         if (stat_c !== es || irq !== b7 || uip !== it.u) begin
            fails++;
            $display("FAIL %s: stat_c=%h irq=%b uip=%b expected stat_c=%h irq=%b uip=%b",
                     t, stat_c, irq, uip, es, b7, it.u);
         end
      end
   end

   task automatic upd_pulse(input string tag);
      upd_busy = 1'b1;
      repeat (3) step(tag);
      upd_busy = 1'b0;
      repeat (3) step(tag);
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      upd_busy = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (stat_c !== 8'h00 || irq !== 1'b0 || uip !== 1'b0) begin
         fails++;
         $display("FAIL R1: stat_c=%h irq=%b uip=%b expected stat_c=00 irq=0 uip=0", stat_c, irq, uip);
      end
      upd_busy = 1'b0;
      rst_n = 1'b1;
      repeat (3) step("R1");

      // R7: rate 0, ticks every cycle, continuous read
      base_tick = 1'b1; stat_rd = 1'b1; rate_sel = 4'd0;
      repeat (10) step("R7");
      // R8: several rates, read held so each event shows for one cycle (R6 too)
      rate_sel = 4'd1;  repeat (6)  step("R8 rate1");
      rate_sel = 4'd3;  repeat (12) step("R8 rate3");
      rate_sel = 4'd2;
      for (int k = 0; k < 12; k++) begin
         base_tick = k[0];
         step("R8 rate2");
      end
      rate_sel = 4'd5;  base_tick = 1'b1; repeat (20) step("R8 rate5");

      // R3/R4: flag sets with enable off, then enables gate the summary only
      stat_rd = 1'b0; rate_sel = 4'd1; ev_en = 3'b000;
      step("R3");
      base_tick = 1'b0;
      repeat (2) step("R3");
      ev_en = 3'b100; repeat (2) step("R4");
      ev_en = 3'b011; repeat (2) step("R4");

      // R5: read clears
      stat_rd = 1'b1; step("R5");
      stat_rd = 1'b0; repeat (2) step("R5");

      // R9/R10: matching alarm with date compared
      now_sec = 8'h30; now_min = 8'h15; now_hour = 8'h08; now_date = 8'h12;
      alm_sec = 8'h30; alm_min = 8'h15; alm_hour = 8'h08; alm_date = 8'h12;
      upd_pulse("R9 R10");
      stat_rd = 1'b1; step("R2 R5"); stat_rd = 1'b0;

      // R11: date differs
      alm_date = 8'h13; upd_pulse("R11 date");
      // R10: date ignored when alarm date is 0
      stat_rd = 1'b1; step("R5"); stat_rd = 1'b0;
      alm_date = 8'h00; now_date = 8'h05; ev_en = 3'b010;
      upd_pulse("R10 nodate");
      // R11: seconds differ
      stat_rd = 1'b1; step("R5"); stat_rd = 1'b0;
      now_sec = 8'h31; upd_pulse("R11 sec");

      // R6: update end in the same cycle as a read
      ev_en = 3'b001;
      upd_busy = 1'b1; repeat (2) step("R6");
      upd_busy = 1'b0; stat_rd = 1'b1; step("R6");
      stat_rd = 1'b0; repeat (2) step("R6");

      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule